// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Unit

This block keeps the interrupt bookkeeping for a pair of serial channels, A and B. For each channel it holds four flags: receive pending, receive in service, transmit pending and transmit in service. It also holds two data-path status bits, receive-available and transmit-empty. Single-cycle event pulses from the channel data paths move these flags: a byte arriving, the host reading the data register, the host writing it, and the transmitter finishing a byte. Two decoded control commands move them too. One clears the transmit interrupt and the other resets the highest in-service level.

The flags, together with the per-channel enables and the break status, produce three things. The first is one combined interrupt request line. The second is a modified interrupt vector, whose 3-bit source code sits at one of two bit positions selected by a status-high control. The third is a 6-bit pending-status image that software can read.

A receive that is in service keeps a transmit request from entering service. When the receive is released, the transmit request is presented. Flag, status and vector updates are registered. The request line is formed from the registered flags and the live enable and break inputs.

Top module: `sio_irq_vector`

## Requirements
- R1: `irq_o` is high when either channel meets any one of three conditions. The first is transmit interrupts enabled (`tx_ie_i`) with transmit pending. The second is that channel's 2-bit receive mode equal to 01 or 10 with receive pending. The third is break interrupts enabled (`brk_ie_i`) with `brk_stat_i` high. This is combinational in the current enables and break status.
- R2: A received-byte pulse sets receive pending, receive in service, receive-available and the channel's receive status bit. It also loads the channel's receive vector code.
- R3: A transmit request enters service only while no receive is in service. Entering service loads the transmit vector code and, when `tx_ie_i` is set, the transmit status bit. A request that cannot enter stays pending and changes neither of them.
- R4: With `stat_hi_i` low, `vector_o` is 0x06 for no source, 0x0C for Rx A, 0x04 for Rx B, 0x08 for Tx A and 0x00 for Tx B.
- R5: With `stat_hi_i` high, `vector_o` is 0x60 for no source, 0x30 for Rx A, 0x20 for Rx B, 0x10 for Tx A and 0x00 for Tx B. The stored source is shown in the format selected by the current `stat_hi_i`.
- R6: `pend_o` has the following layout. Bit 5 is Rx A, bit 4 is Tx A, bit 3 is break A, bit 2 is Rx B, bit 1 is Tx B and bit 0 is break B. Each break bit is the registered value of that channel's enabled break condition. Transmit bits are set only while transmit interrupts are enabled.
- R7: A data write clears transmit pending and transmit-empty. A transmit-done pulse sets transmit-empty and raises transmit pending again, as in R3.
- R8: A data read clears receive-available, receive pending, receive in service and the receive status bit, and loads the no-source vector code. A pending transmit is then brought into service.
- R9: The clear-transmit command clears transmit pending, transmit in service and the transmit status bit, and loads the no-source vector code. A still-pending receive is then re-presented: it is put back in service and its vector code is loaded.
- R10: The reset-highest-in-service command clears receive in service if it is set, and a pending transmit then enters service. Otherwise it clears transmit in service.
- R11: Events arriving together on one channel are folded in a fixed order: data read, received byte, clear-transmit, reset-in-service, data write, transmit done. When both channels change the vector in the same cycle, channel A's code is kept.
- R12: After reset the block shows vector code "no source", `pend_o` = 0, `irq_o` = 0, `tx_empty_o` = 2'b11 and `rx_avail_o` = 2'b00.
- R13: Every flag, status bit and vector change caused by an event is visible on the clock edge that samples the event. Index 0 of every 2-bit port is channel A and index 1 is channel B. `rx_mode_i[1:0]` belongs to A and `rx_mode_i[3:2]` to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_hi_i | input | 1 | Selects the high vector bit position |
| tx_ie_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, 2 bits per channel |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| brk_stat_i | input | 2 | Break status per channel |
| rx_byte_i | input | 2 | Received-byte pulse |
| data_rd_i | input | 2 | Data-register read pulse |
| data_wr_i | input | 2 | Data-register write pulse |
| tx_done_i | input | 2 | Transmitted-byte-complete pulse |
| cmd_clr_tx_i | input | 2 | Clear-transmit-interrupt command pulse |
| cmd_rst_ius_i | input | 2 | Reset-highest-in-service command pulse |
| irq_o | output | 1 | Combined interrupt request |
| vector_o | output | 8 | Modified interrupt vector |
| pend_o | output | 6 | Pending-status image |
| rx_avail_o | output | 2 | Receive character available |
| tx_empty_o | output | 2 | Transmit buffer empty |

## Verification
The bench first looks at a transmit completing while a receive is in service. A design that let the transmit enter anyway would switch the vector to the transmit code and set the Tx status bit too early. Releasing the receive, by a data read or by reset-in-service, must then bring the waiting transmit forward. A design that forgot this would leave the vector on "no source" while the request line stays high. Clear-transmit with a receive still pending must re-present the receive code instead of leaving the vector on "no source". Same-cycle pairs are also driven: a byte with transmit-done, a write with transmit-done, and bytes on both channels. These expose a wrong event order or the wrong winner for the vector. A disabled receive mode, transmit interrupts turned off, and a break condition each confirm the request line and the status bits. The same source codes are also checked in both vector formats.

// File: rtl/sio_iv_pkg.sv
package sio_iv_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [1:0] {
      EV_KEEP = 2'd0,
      EV_IDLE = 2'd1,
      EV_RX   = 2'd2,
      EV_TX   = 2'd3
   } vec_ev_e;

   typedef struct packed {
      logic rx_pend;
      logic rx_ius;
      logic tx_pend;
      logic tx_ius;
      logic st_rx;
      logic st_tx;
      logic rx_avail;
      logic tx_empty;
   } chan_st_t;

   // Source code: bit2 = channel A, bit1 = receive, idle = 3'b011
   function automatic logic [CODE_W-1:0] src_code(vec_ev_e ev, logic is_a);
      case (ev)
         EV_RX:   src_code = {is_a, 1'b1, 1'b0};
         EV_TX:   src_code = {is_a, 1'b0, 1'b0};
         default: src_code = 3'b011;
      endcase
   endfunction

   function automatic chan_st_t enter_tx(chan_st_t s, logic ie);
      chan_st_t r;
      r        = s;
      r.tx_ius = 1'b1;
      if (ie) r.st_tx = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/sio_iv_chan.sv
module sio_iv_chan
   import sio_iv_pkg::*;
#(
   parameter bit TX_EMPTY_RST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_ie_i,
   input  logic [1:0] rx_mode_i,
   input  logic       brk_ie_i,
   input  logic       brk_stat_i,
   input  logic       rx_byte_i,
   input  logic       data_rd_i,
   input  logic       data_wr_i,
   input  logic       tx_done_i,
   input  logic       cmd_clr_tx_i,
   input  logic       cmd_rst_ius_i,
   output logic       irq_o,
   output vec_ev_e    vec_ev_o,
   output logic       st_rx_o,
   output logic       st_tx_o,
   output logic       st_brk_o,
   output logic       rx_avail_o,
   output logic       tx_empty_o
);

   chan_st_t cur_q, nxt;
   vec_ev_e  ev;
   logic     brk_q;
   logic     rx_mode_on;

   // Events folded in fixed order (R11)
   always_comb begin
      nxt = cur_q;
      ev  = EV_KEEP;
      if (data_rd_i) begin
         nxt.rx_avail = 1'b0;
         nxt.rx_pend  = 1'b0;
         nxt.rx_ius   = 1'b0;
         nxt.st_rx    = 1'b0;
         ev           = EV_IDLE;
         if (nxt.tx_pend) begin
            nxt = enter_tx(nxt, tx_ie_i);
            ev  = EV_TX;
         end
      end
      if (rx_byte_i) begin
         nxt.rx_avail = 1'b1;
         nxt.rx_pend  = 1'b1;
         nxt.rx_ius   = 1'b1;
         nxt.st_rx    = 1'b1;
         ev           = EV_RX;
      end
      if (cmd_clr_tx_i) begin
         nxt.tx_pend = 1'b0;
         nxt.tx_ius  = 1'b0;
         nxt.st_tx   = 1'b0;
         ev          = EV_IDLE;
         if (nxt.rx_pend) begin
            nxt.rx_ius = 1'b1;
            nxt.st_rx  = 1'b1;
            ev         = EV_RX;
         end
      end
      if (cmd_rst_ius_i) begin
         if (nxt.rx_ius) begin
            nxt.rx_ius = 1'b0;
            if (nxt.tx_pend) begin
               nxt = enter_tx(nxt, tx_ie_i);
               ev  = EV_TX;
            end
         end else begin
            nxt.tx_ius = 1'b0;
         end
      end
      if (data_wr_i) begin
         nxt.tx_pend  = 1'b0;
         nxt.tx_empty = 1'b0;
      end
      if (tx_done_i) begin
         nxt.tx_empty = 1'b1;
         nxt.tx_pend  = 1'b1;
         if (!nxt.rx_ius) begin
            nxt = enter_tx(nxt, tx_ie_i);
            ev  = EV_TX;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q          <= '0;
         cur_q.tx_empty <= TX_EMPTY_RST;
         brk_q          <= 1'b0;
      end else begin
         cur_q <= nxt;
         brk_q <= brk_ie_i & brk_stat_i;
      end
   end

   assign rx_mode_on = (rx_mode_i == 2'b01) || (rx_mode_i == 2'b10);
   assign irq_o      = (tx_ie_i & cur_q.tx_pend) | (rx_mode_on & cur_q.rx_pend) |
                       (brk_ie_i & brk_stat_i);
   assign vec_ev_o   = ev;
   assign st_rx_o    = cur_q.st_rx;
   assign st_tx_o    = cur_q.st_tx;
   assign st_brk_o   = brk_q;
   assign rx_avail_o = cur_q.rx_avail;
   assign tx_empty_o = cur_q.tx_empty;

   // R2
   rx_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_i |=> (cur_q.rx_pend && cur_q.rx_ius && cur_q.rx_avail));

   // R7
   wr_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && !tx_done_i) |=> (!cur_q.tx_pend && !cur_q.tx_empty));

   // R7
   done_raises_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done_i |=> (cur_q.tx_pend && cur_q.tx_empty));

   // R8
   rd_clears_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && !rx_byte_i) |=> (!cur_q.rx_pend && !cur_q.rx_avail && !cur_q.st_rx));

   // R3
   tx_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done_i && cur_q.rx_ius && !data_rd_i && !cmd_rst_ius_i && !cmd_clr_tx_i &&
       !cur_q.tx_ius) |=> !cur_q.tx_ius);

endmodule

// File: rtl/sio_iv_fmt.sv
module sio_iv_fmt
   import sio_iv_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int LO_POS = 1,
   parameter int HI_POS = 4
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              stat_hi_i,
   output logic [VEC_W-1:0]  vector_o
);

   logic [CODE_W-1:0] code_rev;
   logic [VEC_W-1:0]  lo_vec, hi_vec;

   // High format carries the source code bit-reversed
   for (genvar b = 0; b < CODE_W; b++) begin : g_rev
      assign code_rev[b] = code_i[CODE_W-1-b];
   end

   always_comb begin
      lo_vec = '0;
      hi_vec = '0;
      lo_vec[LO_POS +: CODE_W] = code_i;
      hi_vec[HI_POS +: CODE_W] = code_rev;
   end

   assign vector_o = stat_hi_i ? hi_vec : lo_vec;

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
   import sio_iv_pkg::*;
#(
   parameter int NCH          = 2,
   parameter int VEC_W        = 8,
   parameter int LO_POS       = 1,
   parameter int HI_POS       = 4,
   parameter bit TX_EMPTY_RST = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stat_hi_i,
   input  logic [1:0]     tx_ie_i,
   input  logic [3:0]     rx_mode_i,
   input  logic [1:0]     brk_ie_i,
   input  logic [1:0]     brk_stat_i,
   input  logic [1:0]     rx_byte_i,
   input  logic [1:0]     data_rd_i,
   input  logic [1:0]     data_wr_i,
   input  logic [1:0]     tx_done_i,
   input  logic [1:0]     cmd_clr_tx_i,
   input  logic [1:0]     cmd_rst_ius_i,
   output logic           irq_o,
   output logic [7:0]     vector_o,
   output logic [5:0]     pend_o,
   output logic [1:0]     rx_avail_o,
   output logic [1:0]     tx_empty_o
);

   localparam int PEND_W = 3 * NCH;
   localparam logic [CODE_W-1:0] IDLE_CODE = 3'b011;

   if (NCH != 2) begin : g_bad_nch
      $error("sio_irq_vector: exactly two channels are supported");
   end
   if (LO_POS + CODE_W > VEC_W || HI_POS + CODE_W > VEC_W || VEC_W != 8) begin : g_bad_pos
      $error("sio_irq_vector: vector field positions do not fit");
   end

   logic    [NCH-1:0]    ch_irq;
   vec_ev_e              ch_ev [NCH];
   logic    [NCH-1:0]    ch_rx, ch_tx, ch_brk;
   logic    [CODE_W-1:0] code_q, code_nxt;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      sio_iv_chan #(.TX_EMPTY_RST(TX_EMPTY_RST)) u_chan (
         .clk           (clk),
         .rst_n         (rst_n),
         .tx_ie_i       (tx_ie_i[c]),
         .rx_mode_i     (rx_mode_i[2*c +: 2]),
         .brk_ie_i      (brk_ie_i[c]),
         .brk_stat_i    (brk_stat_i[c]),
         .rx_byte_i     (rx_byte_i[c]),
         .data_rd_i     (data_rd_i[c]),
         .data_wr_i     (data_wr_i[c]),
         .tx_done_i     (tx_done_i[c]),
         .cmd_clr_tx_i  (cmd_clr_tx_i[c]),
         .cmd_rst_ius_i (cmd_rst_ius_i[c]),
         .irq_o         (ch_irq[c]),
         .vec_ev_o      (ch_ev[c]),
         .st_rx_o       (ch_rx[c]),
         .st_tx_o       (ch_tx[c]),
         .st_brk_o      (ch_brk[c]),
         .rx_avail_o    (rx_avail_o[c]),
         .tx_empty_o    (tx_empty_o[c])
      );
      // Channel A occupies the upper three status bits
      assign pend_o[3*(NCH-1-c) +: 3] = {ch_rx[c], ch_tx[c], ch_brk[c]};
   end

   // Channel A wins the vector when both channels update (R11)
   always_comb begin
      code_nxt = code_q;
      if (ch_ev[1] != EV_KEEP) code_nxt = src_code(ch_ev[1], 1'b0);
      if (ch_ev[0] != EV_KEEP) code_nxt = src_code(ch_ev[0], 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= IDLE_CODE;
      else        code_q <= code_nxt;
   end

   sio_iv_fmt #(.VEC_W(VEC_W), .LO_POS(LO_POS), .HI_POS(HI_POS)) u_fmt (
      .code_i    (code_q),
      .stat_hi_i (stat_hi_i),
      .vector_o  (vector_o)
   );

   assign irq_o = |ch_irq;

   // R1
   quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_ie_i == 2'b00) && (brk_ie_i == 2'b00) &&
       (rx_mode_i[1:0] == 2'b00 || rx_mode_i[1:0] == 2'b11) &&
       (rx_mode_i[3:2] == 2'b00 || rx_mode_i[3:2] == 2'b11)) |-> !irq_o);

   // R11
   a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte_i == 2'b11 && data_rd_i == 2'b00 && cmd_clr_tx_i == 2'b00 &&
       cmd_rst_ius_i == 2'b00 && tx_done_i == 2'b00) |=> code_q[2]);

endmodule

// File: tb/sio_irq_vector_bench.sv
module sio_irq_vector_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stat_hi = 1'b0;
   logic [1:0] tx_ie = 2'b11;
   logic [3:0] rx_mode = 4'b1001;
   logic [1:0] brk_ie = 2'b00, brk_stat = 2'b00;
   logic [1:0] rx_byte = '0, data_rd = '0, data_wr = '0, tx_done = '0;
   logic [1:0] clr_tx = '0, rst_ius = '0;
   logic       irq;
   logic [7:0] vector;
   logic [5:0] pend;
   logic [1:0] rx_avail, tx_empty;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sio_irq_vector u_sio_irq_vector (
      .clk(clk), .rst_n(rst_n), .stat_hi_i(stat_hi), .tx_ie_i(tx_ie),
      .rx_mode_i(rx_mode), .brk_ie_i(brk_ie), .brk_stat_i(brk_stat),
      .rx_byte_i(rx_byte), .data_rd_i(data_rd), .data_wr_i(data_wr),
      .tx_done_i(tx_done), .cmd_clr_tx_i(clr_tx), .cmd_rst_ius_i(rst_ius),
      .irq_o(irq), .vector_o(vector), .pend_o(pend),
      .rx_avail_o(rx_avail), .tx_empty_o(tx_empty)
   );

   // Pulses {rx_byte, data_rd, data_wr, tx_done, clr_tx, rst_ius} ([1]=B,[0]=A),
   // then expected irq, vector, pend. Enables: tx_ie=11, A mode 01, B mode 10.
   localparam int NSTEP = 17;
   localparam logic [26:0] TBL [NSTEP] = '{
      {2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 1'b1, 8'h0C, 6'h20}, // R2
      {2'b00,2'b00,2'b00,2'b01,2'b00,2'b00, 1'b1, 8'h0C, 6'h20}, // R3 blocked
      {2'b00,2'b00,2'b00,2'b00,2'b00,2'b01, 1'b1, 8'h08, 6'h30}, // R10
      {2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 1'b1, 8'h08, 6'h10}, // R8
      {2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 1'b0, 8'h06, 6'h00}, // R9
      {2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 1'b1, 8'h04, 6'h04}, // R2 B
      {2'b00,2'b00,2'b10,2'b00,2'b00,2'b00, 1'b1, 8'h04, 6'h04}, // R7
      {2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 1'b1, 8'h04, 6'h04}, // R3 B
      {2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 1'b1, 8'h04, 6'h04}, // R9 re-present
      {2'b00,2'b10,2'b00,2'b00,2'b00,2'b00, 1'b0, 8'h06, 6'h00}, // R8 B
      {2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 1'b1, 8'h0C, 6'h24}, // R11
      {2'b00,2'b11,2'b00,2'b00,2'b00,2'b00, 1'b0, 8'h06, 6'h00}, // R8 both
      {2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 1'b1, 8'h00, 6'h02}, // R4 Tx B
      {2'b00,2'b00,2'b00,2'b00,2'b00,2'b10, 1'b1, 8'h00, 6'h02}, // R10 tx ius
      {2'b00,2'b00,2'b10,2'b00,2'b00,2'b00, 1'b0, 8'h00, 6'h02}, // R7 write
      {2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 1'b1, 8'h00, 6'h02}, // R7 done
      {2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 1'b0, 8'h06, 6'h00}  // R9
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic pulse(input logic [11:0] p);
      @(negedge clk);
      {rx_byte, data_rd, data_wr, tx_done, clr_tx, rst_ius} = p;
      @(negedge clk);
      {rx_byte, data_rd, data_wr, tx_done, clr_tx, rst_ius} = '0;
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      // R12 reset state
      chk("R12 irq", 32'(irq), 32'h0);
      chk("R12 vector", 32'(vector), 32'h06);
      chk("R12 pend", 32'(pend), 32'h0);
      chk("R12 tx_empty", 32'(tx_empty), 32'h3);
      chk("R12 rx_avail", 32'(rx_avail), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R12 after release", 32'(vector), 32'h06);

      for (int i = 0; i < NSTEP; i++) begin
         pulse(TBL[i][26:15]);
         chk($sformatf("R13 step %0d irq", i), 32'(irq), 32'(TBL[i][14]));
         chk($sformatf("R4 step %0d vector", i), 32'(vector), 32'(TBL[i][13:6]));
         chk($sformatf("R6 step %0d pend", i), 32'(pend), 32'(TBL[i][5:0]));
      end
      chk("R7 tx_empty restored", 32'(tx_empty), 32'h3);

      // R5 high-position vector format
      @(negedge clk); stat_hi = 1'b1; #1;
      chk("R5 idle high", 32'(vector), 32'h60);
      pulse({2'b01,10'b0});
      chk("R5 Rx A high", 32'(vector), 32'h30);
      chk("R2 rx_avail", 32'(rx_avail), 32'h1);
      pulse({2'b00,2'b01,8'b0});
      chk("R8 rx_avail clear", 32'(rx_avail), 32'h0);
      chk("R5 idle again", 32'(vector), 32'h60);
      pulse({2'b10,10'b0});
      chk("R5 Rx B high", 32'(vector), 32'h20);
      pulse({2'b00,2'b10,8'b0});
      pulse({6'b0,2'b01,4'b0});
      chk("R5 Tx A high", 32'(vector), 32'h10);
      chk("R6 Tx A bit", 32'(pend), 32'h10);
      pulse({8'b0,2'b01,2'b00});
      // R6 transmit interrupts disabled on B
      @(negedge clk); tx_ie = 2'b01;
      pulse({6'b0,2'b10,4'b0});
      chk("R5 Tx B high", 32'(vector), 32'h00);
      chk("R6 Tx bit held off", 32'(pend), 32'h00);
      chk("R1 tx disabled no irq", 32'(irq), 32'h0);
      pulse({8'b0,2'b10,2'b00});
      @(negedge clk); tx_ie = 2'b11; stat_hi = 1'b0; #1;
      chk("R4 idle low", 32'(vector), 32'h06);

      // R1 receive mode 11 gives no request
      @(negedge clk); rx_mode = 4'b1011;
      pulse({2'b01,10'b0});
      chk("R1 mode 11 irq", 32'(irq), 32'h0);
      chk("R6 Rx A bit", 32'(pend), 32'h20);
      pulse({2'b00,2'b01,8'b0});
      @(negedge clk); rx_mode = 4'b1001;

      // R1 break request, R6 break status bit
      @(negedge clk); brk_ie = 2'b01; brk_stat = 2'b01; #1;
      chk("R1 break irq", 32'(irq), 32'h1);
      @(negedge clk); #1;
      chk("R6 break A bit", 32'(pend), 32'h08);
      @(negedge clk); brk_stat = 2'b00; #1;
      chk("R1 break gone", 32'(irq), 32'h0);
      @(negedge clk); #1;
      chk("R6 break cleared", 32'(pend), 32'h00);
      brk_ie = 2'b00;

      // R11 same-cycle byte and transmit done on A
      pulse({2'b01,4'b0,2'b01,4'b0});
      chk("R11 byte+done vector", 32'(vector), 32'h0C);
      chk("R3 byte+done pend", 32'(pend), 32'h20);
      pulse({2'b00,2'b01,8'b0});
      chk("R8 presents tx", 32'(vector), 32'h08);
      chk("R8 presents tx pend", 32'(pend), 32'h10);
      pulse({4'b0,2'b01,2'b01,4'b0});
      chk("R11 write+done irq", 32'(irq), 32'h1);
      chk("R11 write+done tx_empty", 32'(tx_empty), 32'h3);
      pulse({8'b0,2'b01,2'b00});
      chk("R9 cleared irq", 32'(irq), 32'h0);

      // R7 write alone on A
      pulse({4'b0,2'b01,6'b0});
      chk("R7 tx_empty low", 32'(tx_empty), 32'h2);
      chk("R7 write no irq", 32'(irq), 32'h0);
      pulse({6'b0,2'b01,4'b0});
      chk("R7 done sets empty", 32'(tx_empty), 32'h3);
      chk("R7 done irq", 32'(irq), 32'h1);
      pulse({8'b0,2'b01,2'b00});

      finish_run();
   end

endmodule